// File: doc/BRIEF.md
# Mode-Selected Clock Prescaler

This block turns one fast input clock into two slower square waves. A single free-running counter advances on every rising edge of the fast clock. The amount added on each edge is a power of two picked from a 7-bit clock-mode word. A larger step makes the counter's upper bits toggle sooner, so a larger step gives faster derived clocks.

Two counter bits are brought out through output flops. The second-highest bit serves as a reference for an emulated PLL. The highest bit serves as the core clock. A functional boost input overrides the mode word and selects the largest step, so a design held in reset still sees a fast core clock.

A separate asynchronous active-low reset puts the counter and the tap flops at zero. Its release is synchronised to the fast clock. The boost input never clears the counter.

Top module: `clk_prescaler`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `pll_clk_o` and `core_clk_o` are all zero.
- R2: With boost low, a mode word whose low three bits are 001 (any upper bits) adds 1 per clock.
- R3: With boost low, mode xxxx000 adds 512 per clock and mode x1xx010 adds 256 per clock; at most one step bit is ever set.
- R4: With boost low, mode 11xx011 adds 256 and mode 11xx100 adds 512 per clock.
- R5: With boost low, mode 11xx101 adds 1024 and mode 11xx110 adds 2048 per clock.
- R6: With boost low, mode 11xx111 adds 4096 per clock.
- R7: With `force_fast_i` high, the counter adds 4096 per clock whatever the mode word.
- R8: With boost low and a mode word that matches none of the patterns in R2 to R6 (for example 0000011, 1000111, 0001010), the counter holds its value.
- R9: The counter wraps modulo 8192: 8191 plus 1 gives 0, and a sum past 8191 keeps only its low 13 bits.
- R10: `pll_clk_o` equals counter bit 11 one clock earlier and `core_clk_o` equals counter bit 12 one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| force_fast_i | input | 1 | Selects the largest step regardless of the mode word |
| mode_i | input | 7 | Clock-mode word |
| pll_clk_o | output | 1 | Registered copy of counter bit 11 |
| core_clk_o | output | 1 | Registered copy of counter bit 12 |
| count_o | output | 13 | Current counter value |

## Verification
The bench builds the block with its defaults: a 13-bit counter and a 7-bit mode word. At that width the largest step wraps the counter every second clock, and the two middle steps carry into bits 11 and 12 within a few dozen clocks. Wrap and tap toggling in both phases are therefore reached in short runs of each mode. The slow mode is driven mainly to confirm the single-unit step and to pass from one mode to the next with a known counter value.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;

  typedef enum logic [2:0] {
    RATE_HOLD,
    RATE_SLOW,
    RATE_X1,
    RATE_X2,
    RATE_X4,
    RATE_X8,
    RATE_X16
  } rate_e;

  typedef struct packed {
    logic       ext_on;
    logic       osc_on;
    logic [1:0] drive;
    logic [2:0] sel;
  } mode_t;

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/prs_mode_decode.sv
module prs_mode_decode
  import clk_prescaler_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int MODE_W = 7
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              force_fast_i,
  output logic [CNT_W-1:0]  step_o
);
  localparam int POS_X16  = CNT_W - 1;
  localparam int POS_X8   = CNT_W - 2;
  localparam int POS_X4   = CNT_W - 3;
  localparam int POS_X2   = CNT_W - 4;
  localparam int POS_X1   = CNT_W - 5;
  localparam int POS_SLOW = 0;

  mode_t mode;
  rate_e rate;
  logic  ext_pll;

  assign mode    = mode_t'(mode_i[6:0]);
  assign ext_pll = mode.ext_on & mode.osc_on;

  always_comb begin
    rate = RATE_HOLD;
    if (force_fast_i) begin
      rate = RATE_X16;
    end else begin
      unique case (mode.sel)
        3'b111: if (ext_pll) rate = RATE_X16;
        3'b110: if (ext_pll) rate = RATE_X8;
        3'b101: if (ext_pll) rate = RATE_X4;
        3'b100: if (ext_pll) rate = RATE_X2;
        3'b000: rate = RATE_X2;
        3'b011: if (ext_pll) rate = RATE_X1;
        3'b010: if (mode.osc_on) rate = RATE_X1;
        3'b001: rate = RATE_SLOW;
        default: rate = RATE_HOLD;
      endcase
    end
  end

  always_comb begin
    step_o = '0;
    unique case (rate)
      RATE_X16: step_o[POS_X16]  = 1'b1;
      RATE_X8:  step_o[POS_X8]   = 1'b1;
      RATE_X4:  step_o[POS_X4]   = 1'b1;
      RATE_X2:  step_o[POS_X2]   = 1'b1;
      RATE_X1:  step_o[POS_X1]   = 1'b1;
      RATE_SLOW: step_o[POS_SLOW] = 1'b1;
      default:  step_o = '0;
    endcase
  end
endmodule

// File: rtl/prs_step_counter.sv
module prs_step_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = |step_i;
    cnt_d  = cnt_q + step_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/prs_tap_reg.sv
module prs_tap_reg #(
  parameter int CNT_W  = 13,
  parameter int N_TAPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [N_TAPS-1:0] tap_o
);
  localparam int TAP_LO = CNT_W - N_TAPS;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    logic tap_q;
    logic tap_d;

    always_comb tap_d = cnt_i[TAP_LO + t];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q <= 1'b0;
      else         tap_q <= tap_d;
    end

    assign tap_o[t] = tap_q;
  end
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int CNT_W  = 13,
  parameter int MODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_fast_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              pll_clk_o,
  output logic              core_clk_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int N_TAPS = 2;

  logic              rst_sync_n;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  cnt;
  logic [N_TAPS-1:0] taps;

  prs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  prs_mode_decode #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_dec (
    .mode_i      (mode_i),
    .force_fast_i(force_fast_i),
    .step_o      (step)
  );

  prs_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .step_i(step),
    .cnt_o (cnt)
  );

  prs_tap_reg #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_tap (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .cnt_i (cnt),
    .tap_o (taps)
  );

  assign pll_clk_o  = taps[0];
  assign core_clk_o = taps[1];
  assign count_o    = cnt;
endmodule

// File: rtl/clk_prescaler_checker.sv
module clk_prescaler_checker #(
  parameter int CNT_W  = 13,
  parameter int MODE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_ni,
  input logic              force_fast_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [CNT_W-1:0]  step_i,
  input logic              pll_clk_o,
  input logic              core_clk_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] TOP_STEP = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE_STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic ext_pll;
  logic no_match;
  assign ext_pll  = mode_i[6] & mode_i[5];
  assign no_match = (mode_i[2:0] != 3'b000) && (mode_i[2:0] != 3'b001) &&
                    !(ext_pll && mode_i[2:0] != 3'b010) &&
                    !(mode_i[5] && mode_i[2:0] == 3'b010);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !pll_clk_o && !core_clk_o));

  assert_slow_step_R2: assert property (@(posedge clk_i) disable iff (!run_ni)
    (!force_fast_i && mode_i[2:0] == 3'b001) |=> count_o == $past(count_o) + ONE_STEP);

  assert_onehot_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_i));

  assert_x16_step_R6: assert property (@(posedge clk_i) disable iff (!run_ni)
    (!force_fast_i && ext_pll && mode_i[2:0] == 3'b111) |=> count_o == $past(count_o) + TOP_STEP);

  assert_boost_step_R7: assert property (@(posedge clk_i) disable iff (!run_ni)
    force_fast_i |=> count_o == $past(count_o) + TOP_STEP);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_fast_i && no_match) |=> $stable(count_o));

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!run_ni)
    (!force_fast_i && mode_i[2:0] == 3'b001 && count_o == '1) |=> count_o == '0);

  assert_pll_tap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_clk_o == $past(count_o[CNT_W-2]));

  assert_core_tap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_o == $past(count_o[CNT_W-1]));
endmodule

bind clk_prescaler clk_prescaler_checker #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_ni      (rst_sync_n),
  .force_fast_i(force_fast_i),
  .mode_i      (mode_i),
  .step_i      (step),
  .pll_clk_o   (pll_clk_o),
  .core_clk_o  (core_clk_o),
  .count_o     (count_o)
);

// File: tb/clk_prescaler_tb_top.sv
module clk_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        boost;
  logic [6:0]  mode;
  logic        pll_clk;
  logic        core_clk;
  logic [12:0] count;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic [12:0] cnt;
    logic        pll;
    logic        core;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [12:0] exp_cnt = '0;

  clk_prescaler dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .force_fast_i(boost),
    .mode_i      (mode),
    .pll_clk_o   (pll_clk),
    .core_clk_o  (core_clk),
    .count_o     (count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [12:0] step_of(logic [6:0] m, logic f);
    if (f) return 13'h1000;
    casez (m)
      7'b11??111: return 13'h1000;
      7'b11??110: return 13'h0800;
      7'b11??101: return 13'h0400;
      7'b11??100: return 13'h0200;
      7'b????000: return 13'h0200;
      7'b11??011: return 13'h0100;
      7'b?1??010: return 13'h0100;
      7'b????001: return 13'h0001;
      default:    return 13'h0000;
    endcase
  endfunction

  function automatic string tag_of(logic [6:0] m, logic f);
    if (f) return "R7";
    casez (m)
      7'b11??111: return "R6";
      7'b11??110, 7'b11??101: return "R5";
      7'b11??100, 7'b11??011: return "R4";
      7'b????000, 7'b?1??010: return "R3";
      7'b????001: return "R2";
      default:    return "R8";
    endcase
  endfunction

  task automatic run_mode(input logic [6:0] m, input logic f, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t        e;
      logic [12:0] prev;
      @(negedge clk);
      mode  = m;
      boost = f;
      prev  = exp_cnt;
      exp_cnt = exp_cnt + step_of(m, f);
      e.cnt  = exp_cnt;
      e.pll  = prev[11];
      e.core = prev[12];
      e.tag  = (exp_cnt < prev) ? "R9" : tag_of(m, f);
      sb_q.push_back(e);
    end
  endtask

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, want);
    end
  endtask

  // monitor: compares one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, count, e.cnt);
        check({e.tag, "/R10 pll"},  {12'd0, pll_clk},  {12'd0, e.pll});
        check({e.tag, "/R10 core"}, {12'd0, core_clk}, {12'd0, e.core});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    boost = 1'b0;
    mode  = 7'b0000011;
    repeat (3) @(negedge clk);
    check("R1 count", count, 13'h0000);
    check("R1 taps", {11'd0, core_clk, pll_clk}, 13'h0000);
    // boost during reset must not disturb the cleared state
    boost = 1'b1;
    @(negedge clk);
    check("R1 boost in reset", count, 13'h0000);
    boost = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 hold after release", count, 13'h0000);

    run_mode(7'b0000001, 1'b0, 12);   // R2 slow
    run_mode(7'b1101001, 1'b0, 4);    // R2 with other upper bits
    run_mode(7'b0000000, 1'b0, 20);   // R3 fast RC
    run_mode(7'b0100010, 1'b0, 20);   // R3 crystal
    run_mode(7'b1100011, 1'b0, 20);   // R4 x1
    run_mode(7'b1110100, 1'b0, 20);   // R4 x2
    run_mode(7'b1100101, 1'b0, 20);   // R5 x4
    run_mode(7'b1101110, 1'b0, 20);   // R5 x8
    run_mode(7'b1100111, 1'b0, 10);   // R6 x16, wraps R9
    run_mode(7'b0000011, 1'b0, 5);    // R8 unmatched
    run_mode(7'b1000111, 1'b0, 5);    // R8 unmatched
    run_mode(7'b0001010, 1'b0, 5);    // R8 unmatched
    run_mode(7'b0000001, 1'b1, 6);    // R7 boost over slow
    run_mode(7'b0000011, 1'b1, 6);    // R7 boost over unmatched
    run_mode(7'b1100000, 1'b0, 8);    // R3 xxxx000 with ext bits set
    // bring counter to 8190 then step slow across the wrap (R9)
    run_mode(7'b1100111, 1'b0, 1);
    run_mode(7'b0000001, 1'b0, int'(13'h1FFE - exp_cnt));
    run_mode(7'b0000001, 1'b0, 4);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule